// File: doc/BRIEF.md
# Packed 2-bit pixel shifter

This block turns a stream of packed words into a 2-bit colour signal for a raster display. Each word holds fifteen 2-bit pixels. The block takes words from an external show-ahead FIFO and pops one only when the previous word has been fully used. After reset, software-side logic writes the line length once, as the number of visible pixels minus one (659 for a 660-pixel line). That length then serves every line.

A timing generator sends one active-line pulse per visible row. A fixed lead delay follows the pulse, so the first pixel lines up with the end of the back porch. The block then emits length+1 pixels, leftmost first. The system clock runs at six times the pixel rate, so each pixel is held for six system clocks. Outside a line the output is zero, so blanking is black.

If the FIFO is empty when a new word is needed, that pixel period shows zero and a sticky underrun flag rises. Bits left over from a partly used word are not discarded at the end of a line. They open the next line.

Top module: `pix_shifter`

## Requirements
- R1: After a synchronous reset `pix_o`, `pop_o` and `underrun_o` are 0. Active-line pulses arriving before the length has been written cause no output and no pop.
- R2: The first `len_we_i` after reset stores `len_i` as the line length. Later writes are ignored. Every line then emits exactly `len_i`+1 pixels.
- R3: If `line_go_i` is sampled high at clock edge E, the first pixel appears on `pix_o` at edge E+LEAD (LEAD = 6 by default).
- R4: Each pixel stays on `pix_o` for exactly HOLD system clocks (HOLD = 6 by default).
- R5: A word carries 15 pixels in `word_i[29:0]`. Bits [29:28] are shown first, then [27:26], and so on down to [1:0] last.
- R6: `pop_o` is high for one cycle, together with `word_vld_i`, only when a pixel is due and every pixel of the previous word has been shown. Its first pixel is taken at that same edge.
- R7: `pix_o` is 0 whenever no line is being emitted: while idle, during the lead delay, and from the edge after a line's last pixel period.
- R8: `line_go_i` is ignored during the lead delay and during a line. The line is neither restarted nor repeated.
- R9: If a pixel is due, no bits are left and `word_vld_i` is low, that pixel period shows 0, no word is consumed and `underrun_o` rises and stays high until reset.
- R10: Unused pixels of a partly shown word are kept across the end of a line and are the first pixels of the next line.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock (6x pixel clock) |
| rst | input | 1 | Synchronous active-high reset |
| word_i | input | 30 | Packed head word of the FIFO |
| word_vld_i | input | 1 | FIFO holds a word |
| pop_o | output | 1 | Consume the head word at this edge |
| len_we_i | input | 1 | Write strobe for the line length |
| len_i | input | 10 | Visible pixels per line minus one |
| line_go_i | input | 1 | Active-line pulse from the timing generator |
| pix_o | output | 2 | Pixel colour output |
| underrun_o | output | 1 | Sticky: a word was needed but absent |

## Verification
A line pulse driven at one falling edge is sampled at the next rising edge E. The lead blank is checked at the LEAD falling edges after E. Pixel p is then checked at every one of the HOLD falling edges after edges E+LEAD+p·HOLD through E+LEAD+(p+1)·HOLD−1, and the edge after the last pixel must show zero. Expected pixels come from a scoreboard. It unpacks the bench's own FIFO contents, models underrun and carry-over, and is compared with `pix_o` and with the pop count after each line.

// File: rtl/pxs_pkg.sv
package pxs_pkg;

    localparam int unsigned PIX_BITS     = 2;
    localparam int unsigned PIX_PER_WORD = 15;
    localparam int unsigned HOLD_CLKS    = 6;
    localparam int unsigned LEAD_CLKS    = 6;
    localparam int unsigned LEN_BITS     = 10;

    typedef enum logic [1:0] {
        ST_UNSET,
        ST_IDLE,
        ST_LEAD,
        ST_LINE
    } seq_state_e;

    typedef struct packed {
        logic fetch;   // next pixel is due at this edge
        logic blank;   // line finishes at this edge
    } seq_cmd_t;

    function automatic int unsigned packed_width(input int unsigned pix_bits,
                                                 input int unsigned per_word);
        return pix_bits * per_word;
    endfunction

endpackage

// File: rtl/pxs_line_seq.sv
module pxs_line_seq
    import pxs_pkg::*;
#(
    parameter int unsigned LEN_W = LEN_BITS,
    parameter int unsigned HOLD  = HOLD_CLKS,
    parameter int unsigned LEAD  = LEAD_CLKS
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             len_we,
    input  logic [LEN_W-1:0] len,
    input  logic             line_go,
    output seq_cmd_t         cmd,
    output logic             line_on
);

    localparam int unsigned HOLD_W = (HOLD > 1) ? $clog2(HOLD) : 1;
    localparam int unsigned LEAD_W = $clog2(LEAD + 1);

    seq_state_e         state_q;
    logic [LEN_W-1:0]   len_q;
    logic [LEN_W-1:0]   pcnt_q;
    logic [HOLD_W-1:0]  hcnt_q;
    logic [LEAD_W-1:0]  dcnt_q;

    always_comb begin
        cmd = '0;
        case (state_q)
            ST_LEAD: cmd.fetch = (dcnt_q == LEAD_W'(1));
            ST_LINE: begin
                if (hcnt_q == '0) begin
                    if (pcnt_q == '0) cmd.blank = 1'b1;
                    else              cmd.fetch = 1'b1;
                end
            end
            default: cmd = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_UNSET;
            len_q   <= '0;
            pcnt_q  <= '0;
            hcnt_q  <= '0;
            dcnt_q  <= '0;
        end else begin
            case (state_q)
                ST_UNSET: begin
                    if (len_we) begin
                        len_q   <= len;
                        state_q <= ST_IDLE;
                    end
                end
                ST_IDLE: begin
                    if (line_go) begin
                        dcnt_q  <= LEAD_W'(LEAD);
                        state_q <= ST_LEAD;
                    end
                end
                ST_LEAD: begin
                    if (dcnt_q == LEAD_W'(1)) begin
                        state_q <= ST_LINE;
                        pcnt_q  <= len_q;
                        hcnt_q  <= HOLD_W'(HOLD - 1);
                    end else begin
                        dcnt_q <= dcnt_q - LEAD_W'(1);
                    end
                end
                ST_LINE: begin
                    if (hcnt_q != '0) begin
                        hcnt_q <= hcnt_q - HOLD_W'(1);
                    end else if (pcnt_q == '0) begin
                        state_q <= ST_IDLE;
                    end else begin
                        pcnt_q <= pcnt_q - LEN_W'(1);
                        hcnt_q <= HOLD_W'(HOLD - 1);
                    end
                end
                default: state_q <= ST_UNSET;
            endcase
        end
    end

    assign line_on = (state_q == ST_LINE);

    // R2: once written, the length never changes until reset
    assert_len_frozen_R2: assert property (@(posedge clk) disable iff (rst)
        (state_q != ST_UNSET) |=> $stable(len_q));

    // R4: consecutive pixels are never due on adjacent edges
    assert_hold_gap_R4: assert property (@(posedge clk) disable iff (rst)
        cmd.fetch |=> !cmd.fetch);

    // R8: a pixel period in progress always continues, whatever line_go does
    assert_line_continues_R8: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_LINE && hcnt_q != '0) |=> (state_q == ST_LINE));

endmodule

// File: rtl/pxs_unpacker.sv
module pxs_unpacker
    import pxs_pkg::*;
#(
    parameter int unsigned PIX_W = PIX_BITS,
    parameter int unsigned PPW   = PIX_PER_WORD,
    localparam int unsigned PACK_W = packed_width(PIX_W, PPW)
) (
    input  logic              clk,
    input  logic              rst,
    input  seq_cmd_t          cmd,
    input  logic [PACK_W-1:0] word,
    input  logic              word_vld,
    output logic              pop,
    output logic [PIX_W-1:0]  pix,
    output logic              underrun
);

    localparam int unsigned LEFT_W = (PPW > 1) ? $clog2(PPW) : 1;

    logic [PACK_W-1:0] sreg_q;
    logic [LEFT_W-1:0] left_q;
    logic [PIX_W-1:0]  pix_q;
    logic              under_q;
    logic              need_word;

    assign need_word = cmd.fetch && (left_q == '0);
    assign pop       = need_word && word_vld;

    always_ff @(posedge clk) begin
        if (rst) begin
            sreg_q  <= '0;
            left_q  <= '0;
            pix_q   <= '0;
            under_q <= 1'b0;
        end else if (cmd.fetch) begin
            if (left_q != '0) begin
                pix_q  <= sreg_q[PACK_W-1 -: PIX_W];
                sreg_q <= {sreg_q[PACK_W-PIX_W-1:0], {PIX_W{1'b0}}};
                left_q <= left_q - LEFT_W'(1);
            end else if (word_vld) begin
                pix_q  <= word[PACK_W-1 -: PIX_W];
                sreg_q <= {word[PACK_W-PIX_W-1:0], {PIX_W{1'b0}}};
                left_q <= LEFT_W'(PPW - 1);
            end else begin
                pix_q   <= '0;
                under_q <= 1'b1;
            end
        end else if (cmd.blank) begin
            pix_q <= '0;
        end
    end

    assign pix      = pix_q;
    assign underrun = under_q;

    // R6: a popped word leaves exactly PPW-1 pixels pending
    assert_pop_refills_R6: assert property (@(posedge clk) disable iff (rst)
        pop |=> (left_q == LEFT_W'(PPW - 1)));

    // R9: the underrun flag never falls without reset
    assert_underrun_sticky_R9: assert property (@(posedge clk) disable iff (rst)
        under_q |=> under_q);

    // R9: starved pixel shows zero and raises the flag
    assert_starved_blank_R9: assert property (@(posedge clk) disable iff (rst)
        (need_word && !word_vld) |=> (pix_q == '0 && under_q));

endmodule

// File: rtl/pix_shifter.sv
module pix_shifter
    import pxs_pkg::*;
#(
    parameter int unsigned PIX_W = PIX_BITS,
    parameter int unsigned PPW   = PIX_PER_WORD,
    parameter int unsigned LEN_W = LEN_BITS,
    parameter int unsigned HOLD  = HOLD_CLKS,
    parameter int unsigned LEAD  = LEAD_CLKS,
    localparam int unsigned PACK_W = packed_width(PIX_W, PPW)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [PACK_W-1:0] word_i,
    input  logic              word_vld_i,
    output logic              pop_o,
    input  logic              len_we_i,
    input  logic [LEN_W-1:0]  len_i,
    input  logic              line_go_i,
    output logic [PIX_W-1:0]  pix_o,
    output logic              underrun_o
);

    seq_cmd_t cmd;
    logic     line_on;

    pxs_line_seq #(
        .LEN_W (LEN_W),
        .HOLD  (HOLD),
        .LEAD  (LEAD)
    ) u_seq (
        .clk     (clk),
        .rst     (rst),
        .len_we  (len_we_i),
        .len     (len_i),
        .line_go (line_go_i),
        .cmd     (cmd),
        .line_on (line_on)
    );

    pxs_unpacker #(
        .PIX_W (PIX_W),
        .PPW   (PPW)
    ) u_unpack (
        .clk      (clk),
        .rst      (rst),
        .cmd      (cmd),
        .word     (word_i),
        .word_vld (word_vld_i),
        .pop      (pop_o),
        .pix      (pix_o),
        .underrun (underrun_o)
    );

    // R7: output is black whenever the sequencer is not inside a line
    assert_black_outside_R7: assert property (@(posedge clk) disable iff (rst)
        !line_on |-> (pix_o == '0));

    // R6: nothing is consumed outside a line's pixel schedule
    assert_pop_in_line_R6: assert property (@(posedge clk) disable iff (rst)
        pop_o |-> (cmd.fetch && word_vld_i));

endmodule

// File: tb/pix_shifter_tb.sv
module pix_shifter_tb;

    localparam int HOLD = 6;
    localparam int LEAD = 6;
    localparam int PACK = 30;
    localparam int LW   = 10;
    localparam int PPW  = 15;

    logic            clk = 1'b0;
    logic            rst = 1'b1;
    logic [PACK-1:0] word_i;
    logic            word_vld_i;
    logic            pop_o;
    logic            len_we_i = 1'b0;
    logic [LW-1:0]   len_i = '0;
    logic            line_go_i = 1'b0;
    logic [1:0]      pix_o;
    logic            underrun_o;

    always #2 clk = ~clk;

    pix_shifter u_dut (
        .clk        (clk),
        .rst        (rst),
        .word_i     (word_i),
        .word_vld_i (word_vld_i),
        .pop_o      (pop_o),
        .len_we_i   (len_we_i),
        .len_i      (len_i),
        .line_go_i  (line_go_i),
        .pix_o      (pix_o),
        .underrun_o (underrun_o)
    );

    // bench-side FIFO
    logic [PACK-1:0] fifo_mem [0:255];
    int wr_ptr = 0;
    int rd_ptr = 0;
    assign word_i     = fifo_mem[rd_ptr[7:0]];
    assign word_vld_i = (rd_ptr != wr_ptr);
    always @(posedge clk) if (pop_o) rd_ptr <= rd_ptr + 1;

    // scoreboard model
    int              m_rd = 0;
    int              m_left = 0;
    logic [PACK-1:0] m_sreg = '0;
    logic [1:0]      exp_q[$];
    int              tests = 0;
    int              fails = 0;
    bit              done = 1'b0;

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    function automatic logic [PACK-1:0] mkword(input int k);
        return PACK'(32'h9e3779b9 * (k + 1)) ^ PACK'(k << 7);
    endfunction

    task automatic push_words(input int n);
        for (int i = 0; i < n; i++) begin
            fifo_mem[wr_ptr[7:0]] = mkword(wr_ptr);
            wr_ptr++;
        end
    endtask

    // driver side: expected pixels for one line (R5, R9, R10)
    task automatic expect_line(input int n);
        for (int p = 0; p < n; p++) begin
            if (m_left == 0) begin
                if (m_rd < wr_ptr) begin
                    m_sreg = fifo_mem[m_rd[7:0]];
                    m_rd++;
                    m_left = PPW;
                end else begin
                    exp_q.push_back(2'b00);
                    continue;
                end
            end
            exp_q.push_back(m_sreg[PACK-1 -: 2]);
            m_sreg = m_sreg << 2;
            m_left--;
        end
    endtask

    task automatic run_line(input int n, input bit inj);
        bit ok;
        int act;
        expect_line(n);
        line_go_i = 1'b1;
        fork
            begin
                logic [1:0] e;
                @(negedge clk);
                line_go_i = 1'b0;
                ok = (pix_o == 2'b00);
                for (int k = 2; k <= LEAD; k++) begin
                    @(negedge clk);
                    if (pix_o != 2'b00) ok = 1'b0;
                end
                chk(ok, "R3 R7 blank during lead", pix_o, 0);
                for (int p = 0; p < n; p++) begin
                    e = exp_q.pop_front();
                    ok = 1'b1;
                    act = e;
                    for (int h = 0; h < HOLD; h++) begin
                        @(negedge clk);
                        if (pix_o !== e) begin
                            ok = 1'b0;
                            act = pix_o;
                        end
                    end
                    chk(ok, "R4 R5 pixel value over hold", act, e);
                end
                @(negedge clk);
                chk(pix_o == 2'b00, "R2 R7 black right after last pixel", pix_o, 0);
            end
            begin
                if (inj) begin
                    repeat (40) @(negedge clk);
                    line_go_i = 1'b1;
                    @(negedge clk);
                    line_go_i = 1'b0;
                end
            end
        join
        chk(rd_ptr == m_rd, "R6 words popped per line", rd_ptr, m_rd);
        ok = 1'b1;
        for (int k = 0; k < LEAD + HOLD + 2; k++) begin
            @(negedge clk);
            if (pix_o != 2'b00) ok = 1'b0;
        end
        chk(ok, "R8 no restart from ignored pulse", pix_o, 0);
    endtask

    initial begin
        for (int i = 0; i < 256; i++) fifo_mem[i] = '0;
    end

    initial begin
        bit ok;
        rst = 1'b1;
        repeat (3) @(negedge clk);
        chk(pix_o == 0 && pop_o == 0 && underrun_o == 0, "R1 reset outputs",
            {pix_o, pop_o, underrun_o}, 0);
        rst = 1'b0;

        // R1: pulse before the length is written
        push_words(1);
        line_go_i = 1'b1;
        @(negedge clk);
        line_go_i = 1'b0;
        ok = 1'b1;
        for (int k = 0; k < LEAD + 3 * HOLD; k++) begin
            @(negedge clk);
            if (pix_o != 0 || pop_o) ok = 1'b0;
        end
        chk(ok && rd_ptr == 0, "R1 pulse ignored before length", rd_ptr, 0);

        // R2: first write taken, second ignored
        len_i = 10'd659;
        len_we_i = 1'b1;
        @(negedge clk);
        len_i = 10'd5;
        @(negedge clk);
        len_we_i = 1'b0;

        push_words(43);
        run_line(660, 1'b1);
        chk(underrun_o == 1'b0, "R9 no underrun when fed", underrun_o, 0);
        push_words(44);
        run_line(660, 1'b0);   // R2 length reused
        chk(underrun_o == 1'b0, "R9 no underrun on second line", underrun_o, 0);

        // second phase: short lines
        rst = 1'b1;
        repeat (2) @(negedge clk);
        chk(pix_o == 0 && underrun_o == 0, "R1 outputs after second reset",
            {pix_o, underrun_o}, 0);
        rst = 1'b0;
        m_left = 0;
        len_i = 10'd19;
        len_we_i = 1'b1;
        @(negedge clk);
        len_we_i = 1'b0;

        push_words(1);
        run_line(20, 1'b0);    // R9 starves after 15 pixels
        chk(underrun_o == 1'b1, "R9 underrun raised", underrun_o, 1);
        push_words(2);
        run_line(20, 1'b0);    // leaves 10 pixels pending
        chk(underrun_o == 1'b1, "R9 underrun sticky", underrun_o, 1);
        push_words(1);
        run_line(20, 1'b0);    // R10 leftover opens the line
        chk(rd_ptr == wr_ptr, "R10 carried pixels used before new word", rd_ptr, wr_ptr);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        #(4 * 200000);
        if (!done) begin
            tests++;
            fails++;
            $display("FAIL watchdog: actual 0 expected 1");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

endmodule